// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a stream of input events by a programmable ratio. Each event is one clock cycle in which `in_en` is high. The division works the way a frequency synthesizer's feedback path does. A prescaler counts either M or M+1 input events per prescaler cycle, and M is 32 or 64. A 7-bit swallow count A and an 11-bit main count B set the sequence. In each output period the first A prescaler cycles run at M+1 and the remaining B−A run at M. The total ratio is therefore N = M·B + A, for settings with B ≥ 3 and B ≥ A. With B ≥ M−1 this covers every ratio from M·(M−1) upward without gaps: 992 to 65631 in the narrow mode and 4032 to 131135 in the wide mode.

The block has no data stream. Every pin is a plain control or status signal and there is no back-pressure. `div_pulse` marks each period boundary. `mod_ctrl` shows which modulus the prescaler is using for the current prescaler cycle. Ratio settings are sampled only at a period boundary, at a restart, or on the first clock after reset. Changing them at any other time cannot shorten or stretch a period already in progress.

Top module: `pulse_swallow_divider`

## Requirements
- R1: While `rst_n` is low, `div_pulse` and `mod_ctrl` are both 0.
- R2: With `wide_mode`=0 the modulus M is 32, and with `wide_mode`=1 it is 64. The number of enabled cycles in one output period is M·`main_b` + `swallow_a`.
- R3: Within a period, `mod_ctrl` is 1 during exactly the first `swallow_a`·(M+1) enabled cycles and 0 during the rest.
- R4: When `swallow_a` is 0, `mod_ctrl` stays 0 for the whole period and the period is M·`main_b` enabled cycles.
- R5: `div_pulse` is high for exactly one clock cycle. That cycle directly follows the enabled cycle that completes a period.
- R6: Cycles with `in_en` low do not advance the division, do not change `mod_ctrl`, and never produce a pulse.
- R7: A change on `wide_mode`, `swallow_a` or `main_b` in the middle of a period leaves that period's length unchanged. The new values apply from the next period.
- R8: A cycle with `restart` high loads the present settings and discards any partial count. It ignores `in_en` and produces no pulse. The next period is counted from the following cycle.
- R9: The first clock edge after reset is released acts like a restart and loads the settings present on the inputs.
- R10: With `swallow_a` equal to `main_b`, every prescaler cycle uses M+1, so the period is (M+1)·`main_b` enabled cycles and `mod_ctrl` is 1 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_en | input | 1 | High for one input event in this cycle |
| restart | input | 1 | Synchronous restart; loads the settings |
| wide_mode | input | 1 | Modulus select: 0 gives 32/33, 1 gives 64/65 |
| swallow_a | input | 7 | Swallow count A |
| main_b | input | 11 | Main count B |
| div_pulse | output | 1 | One-cycle pulse at each period boundary |
| mod_ctrl | output | 1 | 1 while the prescaler runs at M+1 |

## Verification
The hardest situation to reach from the ports is a settings change that arrives partway through a period while `in_en` is irregular. A correct design must then finish the old period at the old length and start the new period with the new modulus sequence. The stimulus measures one period cleanly and changes all three settings a few dozen events into the next one. It then checks that the first boundary still matches the old ratio and the second matches the new one. A long run of disabled cycles in mid-period also checks that the prescaler phase and `mod_ctrl` hold their values across the gap.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int SWALLOW_W = 7;
  localparam int MAIN_W    = 11;

  typedef struct packed {
    logic                 wide;
    logic [SWALLOW_W-1:0] a;
    logic [MAIN_W-1:0]    b;
  } psd_cfg_t;
endpackage

// File: rtl/psd_cfg_hold.sv
module psd_cfg_hold
  import psd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  psd_cfg_t cfg_in,
  output psd_cfg_t cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (load) cfg_q <= cfg_in;
  end

  // R7: the held settings move only on a load strobe
  a_r7_cfg_only_at_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_q));
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int LOW_MOD  = 32,
  parameter int HIGH_MOD = 64,
  parameter int PC_W     = $clog2(HIGH_MOD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_en,
  input  logic kick,
  input  logic wide,
  input  logic mod_ctrl,
  output logic pre_end
);
  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] base;
  logic [PC_W-1:0] term;

  generate
    if (HIGH_MOD > LOW_MOD) begin : g_dual
      assign base = wide ? PC_W'(HIGH_MOD) : PC_W'(LOW_MOD);
    end else begin : g_single
      logic unused_wide;
      assign unused_wide = wide;
      assign base = PC_W'(LOW_MOD);
    end
  endgenerate

  assign term    = base - PC_W'(1) + PC_W'(mod_ctrl);
  assign pre_end = in_en && (pc == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc <= '0;
    else if (kick)   pc <= '0;
    else if (in_en)  pc <= pre_end ? '0 : pc + PC_W'(1);
  end

  // R2: the phase counter never runs past the current modulus
  a_r2_pc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pc <= term);
  // R6: idle cycles leave the prescaler phase untouched
  a_r6_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_en && !kick) |=> $stable(pc));
endmodule

// File: rtl/psd_sequencer.sv
module psd_sequencer #(
  parameter int A_W = 7,
  parameter int B_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reload,
  input  logic           pre_end,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  output logic           mod_ctrl,
  output logic           last_main
);
  logic [A_W-1:0] sc;
  logic [B_W-1:0] bc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc <= '0;
      bc <= '0;
    end else if (reload) begin
      sc <= a_in;
      bc <= b_in;
    end else if (pre_end) begin
      bc <= bc - B_W'(1);
      if (sc != '0) sc <= sc - A_W'(1);
    end
  end

  assign mod_ctrl  = (sc != '0);
  assign last_main = (bc <= B_W'(1));

  // R4: a zero swallow count keeps the high modulus off
  a_r4_zero_swallow: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && a_in == '0) |=> !mod_ctrl);
  // R6: without a prescaler boundary or reload the counts hold
  a_r6_counts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_end && !reload) |=> $stable({sc, bc}));
  // R3: the high modulus can only switch off at a prescaler boundary
  a_r3_drop_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_ctrl && !pre_end && !reload) |=> mod_ctrl);
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
  import psd_pkg::*;
#(
  parameter int LOW_MOD  = 32,
  parameter int HIGH_MOD = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_en,
  input  logic                 restart,
  input  logic                 wide_mode,
  input  logic [SWALLOW_W-1:0] swallow_a,
  input  logic [MAIN_W-1:0]    main_b,
  output logic                 div_pulse,
  output logic                 mod_ctrl
);
  localparam int PC_W = $clog2(HIGH_MOD + 1);

  logic     fresh;
  logic     kick;
  logic     pre_end;
  logic     last_main;
  logic     period_end;
  logic     reload;
  psd_cfg_t cfg_in;
  psd_cfg_t cfg_q;

  assign cfg_in     = '{wide: wide_mode, a: swallow_a, b: main_b};
  assign kick       = fresh || restart;
  assign period_end = pre_end && last_main && !kick;
  assign reload     = kick || period_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh     <= 1'b1;
      div_pulse <= 1'b0;
    end else begin
      fresh     <= 1'b0;
      div_pulse <= period_end;
    end
  end

  psd_cfg_hold u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (reload),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_q)
  );

  psd_prescaler #(
    .LOW_MOD  (LOW_MOD),
    .HIGH_MOD (HIGH_MOD),
    .PC_W     (PC_W)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_en    (in_en),
    .kick     (reload),
    .wide     (cfg_q.wide),
    .mod_ctrl (mod_ctrl),
    .pre_end  (pre_end)
  );

  psd_sequencer #(
    .A_W (SWALLOW_W),
    .B_W (MAIN_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .reload    (reload),
    .pre_end   (pre_end),
    .a_in      (swallow_a),
    .b_in      (main_b),
    .mod_ctrl  (mod_ctrl),
    .last_main (last_main)
  );

  // R5: boundary pulse is a single cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);
  // R6: a pulse always follows an enabled cycle
  a_r6_pulse_after_event: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> $past(in_en));
  // R8: a restart cycle never yields a pulse
  a_r8_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !div_pulse);
endmodule

// File: tb/tb_pulse_swallow_divider.sv
module tb_pulse_swallow_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_en = 1'b0;
  logic        restart = 1'b0;
  logic        wide_mode = 1'b0;
  logic [6:0]  swallow_a = '0;
  logic [10:0] main_b = '0;
  logic        div_pulse;
  logic        mod_ctrl;

  int checks = 0, fails = 0;
  int cnt = 0, mhi = 0, last_n = 0, last_hi = 0, pat = 0, dbl = 0;
  bit got_pulse = 0, prev_pulse = 0, done = 0;

  always #4 clk = ~clk;

  pulse_swallow_divider dut (
    .clk(clk), .rst_n(rst_n), .in_en(in_en), .restart(restart),
    .wide_mode(wide_mode), .swallow_a(swallow_a), .main_b(main_b),
    .div_pulse(div_pulse), .mod_ctrl(mod_ctrl)
  );

  // {wide, A, B}
  localparam logic [18:0] VEC [0:7] = '{
    {1'b0, 7'd0,   11'd3},
    {1'b0, 7'd3,   11'd3},
    {1'b0, 7'd5,   11'd10},
    {1'b0, 7'd31,  11'd31},
    {1'b1, 7'd0,   11'd3},
    {1'b1, 7'd7,   11'd9},
    {1'b1, 7'd63,  11'd64},
    {1'b0, 7'd127, 11'd127}
  };

  function automatic int exp_n(input logic w, input int a, input int b);
    return (w ? 64 : 32) * b + a;
  endfunction
  function automatic int exp_hi(input logic w, input int a);
    return a * ((w ? 64 : 32) + 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick(input logic en_v, input logic rs);
    @(negedge clk);
    if (div_pulse) begin
      if (prev_pulse) dbl++;
      got_pulse = 1;
      last_n = cnt; last_hi = mhi; cnt = 0; mhi = 0;
    end
    prev_pulse = div_pulse;
    in_en = en_v; restart = rs;
    if (rs) begin cnt = 0; mhi = 0; end
    else if (en_v) begin cnt++; if (mod_ctrl) mhi++; end
  endtask

  function automatic logic pat_en();
    return ((pat % 7) != 3) && ((pat % 11) != 5);
  endfunction

  task automatic wait_pulse();
    got_pulse = 0;
    for (int i = 0; i < 20000 && !got_pulse; i++) begin
      pat++;
      tick(pat_en(), 1'b0);
    end
  endtask

  task automatic measure(input int en_n, input int en_hi, input string req);
    wait_pulse();
    check(got_pulse, {req, " pulse seen"}, got_pulse, 1);
    check(last_n == en_n, {req, " period length"}, last_n, en_n);
    check(last_hi == en_hi, {req, " mod_ctrl span"}, last_hi, en_hi);
  endtask

  task automatic setcfg(input logic [18:0] v);
    wide_mode = v[18]; swallow_a = v[17:11]; main_b = v[10:0];
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [18:0] v;
    // R1: outputs quiet in reset
    setcfg({1'b0, 7'd5, 11'd10});
    repeat (3) @(negedge clk);
    check(div_pulse == 0, "R1 div_pulse in reset", div_pulse, 0);
    check(mod_ctrl == 0, "R1 mod_ctrl in reset", mod_ctrl, 0);
    rst_n = 1'b1;
    // R9: first edge loads settings (A=5 -> mod_ctrl high)
    tick(1'b0, 1'b0);
    check(mod_ctrl == 1, "R9 load after reset", mod_ctrl, 1);
    measure(325, 165, "R9");

    // Table walk: R2, R3, R4, R10
    for (int k = 0; k < 8; k++) begin
      v = VEC[k];
      setcfg(v);
      tick(1'b0, 1'b1);
      for (int p = 0; p < 2; p++)
        measure(exp_n(v[18], int'(v[17:11]), int'(v[10:0])),
                exp_hi(v[18], int'(v[17:11])),
                (v[17:11] == 0) ? "R4" : (v[17:11] == v[10:0]) ? "R10" : "R2/R3");
    end

    // R7: mid-period change takes effect next period
    setcfg({1'b0, 7'd5, 11'd10});
    tick(1'b0, 1'b1);
    measure(325, 165, "R7 before");
    for (int i = 0; i < 40; i++) begin pat++; tick(pat_en(), 1'b0); end
    setcfg({1'b1, 7'd2, 11'd4});
    measure(325, 165, "R7 old period");
    measure(258, 130, "R7 new period");

    // R8: restart discards partial count, no pulse in restart cycle
    for (int i = 0; i < 50; i++) begin pat++; tick(pat_en(), 1'b0); end
    setcfg({1'b0, 7'd3, 11'd3});
    tick(1'b1, 1'b1);
    tick(1'b1, 1'b0);
    check(div_pulse == 0, "R8 no pulse after restart", div_pulse, 0);
    measure(99, 99, "R8");

    // R6: long idle gap mid-period
    tick(1'b0, 1'b1);
    for (int i = 0; i < 30; i++) tick(1'b1, 1'b0);
    begin
      logic mc0;
      bit seen;
      mc0 = mod_ctrl; seen = 0;
      for (int i = 0; i < 300; i++) begin
        tick(1'b0, 1'b0);
        if (div_pulse || mod_ctrl != mc0) seen = 1;
      end
      check(!seen, "R6 idle holds state", seen, 0);
    end
    measure(99, 99, "R6");

    check(dbl == 0, "R5 pulse width", dbl, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule